// File: doc/BRIEF.md
# Privileged Event Routing Unit

The unit sits next to a processor core's commit point. It collects four classes of pending events and picks the single event that takes control in a given cycle. The classes are machine checks, instruction exceptions (page faults and arithmetic faults), service-request traps and directed interrupts. For the chosen event it reports the privilege layer that receives control, a 6-bit cause code, and whether the handler returns to re-execute the instruction at the commit point or to resume after it.

Each source has a pending flag. A one-cycle raise pulse sets the flag, and the flag clears on the edge at which its event is dispatched. Software chooses which arithmetic faults are recognized and what disposition each one carries. A directed interrupt names the hypervisor and guest it belongs to. It waits until the core has exactly that pair installed.

Layers are encoded as user=0, supervisor=1, hypervisor=2, secure=3. Return mode 0 means re-execute and 1 means resume after.

Top module: `evt_route_unit`

## Requirements
- R1: After reset no source is pending and `dsp_valid_o` stays 0 until an event is raised.
- R2: When several events are pending, exactly one is dispatched per cycle and the others stay pending. The order is check, then exception, then trap, then interrupt. Within a class the lowest source index goes first, and in the exception class both page faults come ahead of all arithmetic faults.
- R3: A check (source c, 0..3) cannot be masked. It goes to layer 3 from any current layer, with cause 48+c and return mode 0.
- R4: Arithmetic exceptions, traps and interrupts go to the current layer plus one. In layer 3 they stay in layer 3.
- R5: An arithmetic raise on bit a (0..7) whose enable bit `arith_en_i[a]` is 0 is discarded. It causes no dispatch, and it causes none later even if the enable is set afterwards.
- R6: A recognized arithmetic fault a has cause 24+a. Its disposition is `arith_disp_i[2a+1:2a]`, with 1=repair, 2=complete and 0 or 3=terminate. Repair gives return mode 0. Complete and terminate give return mode 1.
- R7: A guest page fault (`pf_raise_i[0]`) goes to layer 1 with cause 16. A hypervisor page fault (`pf_raise_i[1]`) goes to layer 2 with cause 17. Both use return mode 0.
- R8: A trap has cause 32 and return mode 1.
- R9: Interrupt line i has cause i and return mode 0. It is dispatched only in a cycle where its target ids equal `cur_hv_id_i` and `cur_gos_id_i`. Otherwise it stays pending and is dispatched once the ids match.
- R10: An event raised at clock edge k is dispatched as a `dsp_valid_o` pulse after edge k+1. A single event gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_layer_i | input | 2 | Layer currently executing |
| cur_hv_id_i | input | ID_W | Installed hypervisor id |
| cur_gos_id_i | input | ID_W | Installed guest OS id |
| chk_raise_i | input | 4 | Check raise: 0 ECC uncorrectable, 1 special privilege, 2 hardware failure, 3 power/reset |
| pf_raise_i | input | 2 | Page fault raise: 0 guest, 1 hypervisor |
| arith_raise_i | input | 8 | Arithmetic raise: 0 operand domain, 1 result range, 2 privilege, 3..7 IEEE invalid, divide-by-zero, overflow, underflow, inexact |
| arith_en_i | input | 8 | Recognition enable per arithmetic source |
| arith_disp_i | input | 16 | 2-bit disposition per arithmetic source |
| trap_req_i | input | 1 | Service-request trap raise |
| irq_raise_i | input | N_IRQ | Interrupt raise per line |
| irq_hv_id_i | input | N_IRQ*ID_W | Target hypervisor id per line |
| irq_gos_id_i | input | N_IRQ*ID_W | Target guest id per line |
| dsp_valid_o | output | 1 | Dispatch pulse |
| dsp_layer_o | output | 2 | Receiving layer |
| dsp_cause_o | output | 6 | Cause code |
| dsp_ret_o | output | 1 | Return mode: 0 re-execute, 1 resume after |

## Verification
The assertions check on every cycle that checks win over everything and land in the secure layer, and that exceptions win over traps. They also check that a trap's target is one layer above the layer sampled on the dispatch edge, and that page faults carry fixed layers with re-execute return. The discarding of unrecognized arithmetic raises and the disposition mapping need the bench scenarios. So do the full drain order of a cycle with all four classes raised, and the interrupts held back by an id mismatch.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;
  typedef enum logic [1:0] {LYR_USER = 2'd0, LYR_SUP = 2'd1, LYR_HYP = 2'd2, LYR_SEC = 2'd3} layer_e;

  localparam int unsigned N_CHK   = 4;
  localparam int unsigned N_PF    = 2;
  localparam int unsigned N_ARITH = 8;
  localparam int unsigned N_EXC   = N_PF + N_ARITH;
  localparam int unsigned CAUSE_W = 6;

  localparam logic [CAUSE_W-1:0] CAUSE_PF_BASE    = 6'd16;
  localparam logic [CAUSE_W-1:0] CAUSE_ARITH_BASE = 6'd24;
  localparam logic [CAUSE_W-1:0] CAUSE_TRAP       = 6'd32;
  localparam logic [CAUSE_W-1:0] CAUSE_CHK_BASE   = 6'd48;

  localparam logic [1:0] DISP_REPAIR   = 2'd1;
  localparam logic [1:0] DISP_COMPLETE = 2'd2;

  localparam logic RET_REEXEC = 1'b0;
  localparam logic RET_RESUME = 1'b1;

  function automatic layer_e next_layer(input logic [1:0] cur);
    next_layer = (cur == 2'd3) ? LYR_SEC : layer_e'(cur + 2'd1);
  endfunction
endpackage

// File: rtl/evt_pend.sv
module evt_pend #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  // a fresh raise wins over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/evt_prio.sv
module evt_prio #(
  parameter int unsigned W  = 4,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  oh_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    oh_o  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
    if (any_o) oh_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/evt_route_unit.sv
module evt_route_unit
  import evt_route_pkg::*;
#(
  parameter int unsigned ID_W  = 4,
  parameter int unsigned N_IRQ = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            cur_layer_i,
  input  logic [ID_W-1:0]       cur_hv_id_i,
  input  logic [ID_W-1:0]       cur_gos_id_i,
  input  logic [N_CHK-1:0]      chk_raise_i,
  input  logic [N_PF-1:0]       pf_raise_i,
  input  logic [N_ARITH-1:0]    arith_raise_i,
  input  logic [N_ARITH-1:0]    arith_en_i,
  input  logic [2*N_ARITH-1:0]  arith_disp_i,
  input  logic                  trap_req_i,
  input  logic [N_IRQ-1:0]      irq_raise_i,
  input  logic [N_IRQ*ID_W-1:0] irq_hv_id_i,
  input  logic [N_IRQ*ID_W-1:0] irq_gos_id_i,
  output logic                  dsp_valid_o,
  output logic [1:0]            dsp_layer_o,
  output logic [CAUSE_W-1:0]    dsp_cause_o,
  output logic                  dsp_ret_o
);
  localparam int unsigned CHK_IW = $clog2(N_CHK);
  localparam int unsigned EXC_IW = $clog2(N_EXC);
  localparam int unsigned IRQ_IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int unsigned AR_IW  = $clog2(N_ARITH);

  logic [N_CHK-1:0] chk_pend, chk_clr, chk_oh;
  logic [N_EXC-1:0] exc_pend, exc_clr, exc_oh, exc_set;
  logic [N_IRQ-1:0] irq_pend, irq_clr, irq_oh, irq_ok, irq_elig;
  logic [0:0]       trap_pend, trap_clr;
  logic             chk_any, exc_any, irq_any;
  logic [CHK_IW-1:0] chk_idx;
  logic [EXC_IW-1:0] exc_idx;
  logic [IRQ_IW-1:0] irq_idx;
  logic [AR_IW-1:0]  ar_idx;
  logic [1:0]        ar_disp;

  logic               win_v, win_ret;
  layer_e             win_layer;
  logic [CAUSE_W-1:0] win_cause;

  // unrecognized arithmetic raises never enter the pending set
  assign exc_set = {arith_raise_i & arith_en_i, pf_raise_i};

  evt_pend #(.W(N_CHK)) u_chk_pend (.clk_i, .rst_ni, .set_i(chk_raise_i), .clr_i(chk_clr), .pend_o(chk_pend));
  evt_pend #(.W(N_EXC)) u_exc_pend (.clk_i, .rst_ni, .set_i(exc_set),     .clr_i(exc_clr), .pend_o(exc_pend));
  evt_pend #(.W(1))     u_trp_pend (.clk_i, .rst_ni, .set_i(trap_req_i),  .clr_i(trap_clr), .pend_o(trap_pend));
  evt_pend #(.W(N_IRQ)) u_irq_pend (.clk_i, .rst_ni, .set_i(irq_raise_i), .clr_i(irq_clr), .pend_o(irq_pend));

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq_match
    assign irq_ok[g] = (irq_hv_id_i[g*ID_W +: ID_W] == cur_hv_id_i) &&
                       (irq_gos_id_i[g*ID_W +: ID_W] == cur_gos_id_i);
  end
  assign irq_elig = irq_pend & irq_ok;

  evt_prio #(.W(N_CHK)) u_chk_prio (.req_i(chk_pend), .any_o(chk_any), .idx_o(chk_idx), .oh_o(chk_oh));
  evt_prio #(.W(N_EXC)) u_exc_prio (.req_i(exc_pend), .any_o(exc_any), .idx_o(exc_idx), .oh_o(exc_oh));
  evt_prio #(.W(N_IRQ)) u_irq_prio (.req_i(irq_elig), .any_o(irq_any), .idx_o(irq_idx), .oh_o(irq_oh));

  assign ar_idx  = AR_IW'(exc_idx - EXC_IW'(N_PF));
  assign ar_disp = arith_disp_i[{ar_idx, 1'b0} +: 2];

  always_comb begin
    win_v     = 1'b0;
    win_layer = LYR_USER;
    win_cause = '0;
    win_ret   = RET_REEXEC;
    chk_clr   = '0;
    exc_clr   = '0;
    trap_clr  = '0;
    irq_clr   = '0;
    if (chk_any) begin
      win_v     = 1'b1;
      win_layer = LYR_SEC;
      win_cause = CAUSE_CHK_BASE + CAUSE_W'(chk_idx);
      chk_clr   = chk_oh;
    end else if (exc_any) begin
      win_v   = 1'b1;
      exc_clr = exc_oh;
      if (exc_idx < EXC_IW'(N_PF)) begin
        win_layer = (exc_idx == '0) ? LYR_SUP : LYR_HYP;
        win_cause = CAUSE_PF_BASE + CAUSE_W'(exc_idx);
      end else begin
        win_layer = next_layer(cur_layer_i);
        win_cause = CAUSE_ARITH_BASE + CAUSE_W'(ar_idx);
        win_ret   = (ar_disp == DISP_REPAIR) ? RET_REEXEC : RET_RESUME;
      end
    end else if (trap_pend[0]) begin
      win_v     = 1'b1;
      win_layer = next_layer(cur_layer_i);
      win_cause = CAUSE_TRAP;
      win_ret   = RET_RESUME;
      trap_clr  = 1'b1;
    end else if (irq_any) begin
      win_v     = 1'b1;
      win_layer = next_layer(cur_layer_i);
      win_cause = CAUSE_W'(irq_idx);
      irq_clr   = irq_oh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsp_valid_o <= 1'b0;
      dsp_layer_o <= 2'd0;
      dsp_cause_o <= '0;
      dsp_ret_o   <= 1'b0;
    end else begin
      dsp_valid_o <= win_v;
      dsp_layer_o <= win_layer;
      dsp_cause_o <= win_cause;
      dsp_ret_o   <= win_ret;
    end
  end
endmodule

// File: rtl/evt_route_chk.sv
module evt_route_chk
  import evt_route_pkg::*;
(
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   cur_layer_i,
  input logic [N_CHK-1:0]             chk_pend,
  input logic [N_EXC-1:0]             exc_pend,
  input logic                         dsp_valid_o,
  input logic [1:0]                   dsp_layer_o,
  input logic [CAUSE_W-1:0]           dsp_cause_o,
  input logic                         dsp_ret_o
);
  p_chk_secure_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_valid_o && dsp_cause_o[5:4] == 2'b11) |-> (dsp_layer_o == 2'd3 && !dsp_ret_o));

  p_chk_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pend != '0) |=> (dsp_valid_o && dsp_cause_o[5:4] == 2'b11));

  p_exc_before_trap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pend == '0 && exc_pend != '0) |=> (dsp_valid_o && dsp_cause_o[5:4] == 2'b01));

  p_trap_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_valid_o && dsp_cause_o == CAUSE_TRAP) |->
      (dsp_layer_o == next_layer($past(cur_layer_i)) && dsp_ret_o));

  p_pf_repair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_valid_o && (dsp_cause_o == 6'd16 || dsp_cause_o == 6'd17)) |->
      (!dsp_ret_o && dsp_layer_o == ((dsp_cause_o == 6'd16) ? 2'd1 : 2'd2)));
endmodule

bind evt_route_unit evt_route_chk u_evt_route_chk (
  .clk_i, .rst_ni, .cur_layer_i, .chk_pend, .exc_pend,
  .dsp_valid_o, .dsp_layer_o, .dsp_cause_o, .dsp_ret_o
);

// File: tb/evt_route_unit_bench.sv
module evt_route_unit_bench;
  localparam int ID_W  = 4;
  localparam int N_IRQ = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] cur_layer = 2'd0;
  logic [ID_W-1:0] cur_hv = 4'd1, cur_gos = 4'd1;
  logic [3:0] chk_raise = '0;
  logic [1:0] pf_raise = '0;
  logic [7:0] ar_raise = '0, ar_en = '0;
  logic [15:0] ar_disp = '0;
  logic trap_req = 1'b0;
  logic [N_IRQ-1:0] irq_raise = '0;
  logic [N_IRQ*ID_W-1:0] irq_hv, irq_gos;
  logic dsp_valid, dsp_ret;
  logic [1:0] dsp_layer;
  logic [5:0] dsp_cause;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_route_unit #(.ID_W(ID_W), .N_IRQ(N_IRQ)) u_evt_route_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cur_layer_i(cur_layer),
    .cur_hv_id_i(cur_hv), .cur_gos_id_i(cur_gos),
    .chk_raise_i(chk_raise), .pf_raise_i(pf_raise),
    .arith_raise_i(ar_raise), .arith_en_i(ar_en), .arith_disp_i(ar_disp),
    .trap_req_i(trap_req), .irq_raise_i(irq_raise),
    .irq_hv_id_i(irq_hv), .irq_gos_id_i(irq_gos),
    .dsp_valid_o(dsp_valid), .dsp_layer_o(dsp_layer),
    .dsp_cause_o(dsp_cause), .dsp_ret_o(dsp_ret)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_d(string tag, logic v, logic [1:0] lyr, logic [5:0] cause, logic ret);
    n_chk++;
    if (dsp_valid !== v || (v && (dsp_layer !== lyr || dsp_cause !== cause || dsp_ret !== ret))) begin
      n_fail++;
      $display("FAIL %s: got v=%0b lyr=%0d cause=%0d ret=%0b, expected v=%0b lyr=%0d cause=%0d ret=%0b",
               tag, dsp_valid, dsp_layer, dsp_cause, dsp_ret, v, lyr, cause, ret);
    end
  endtask

  // raise is held across one edge, the dispatch edge follows
  task automatic release_and_wait();
    step();
    chk_raise = '0; pf_raise = '0; ar_raise = '0; trap_req = 1'b0; irq_raise = '0;
    step();
  endtask

  task automatic t_reset();
    expect_d("R1 reset", 1'b0, 2'd0, 6'd0, 1'b0);
    step(); step();
    expect_d("R1 idle", 1'b0, 2'd0, 6'd0, 1'b0);
  endtask

  task automatic t_check();
    ar_en = '0; cur_layer = 2'd0;
    chk_raise = 4'b0100;
    release_and_wait();
    expect_d("R3 check user", 1'b1, 2'd3, 6'd50, 1'b0);
    step();
    expect_d("R10 single pulse", 1'b0, 2'd0, 6'd0, 1'b0);
    cur_layer = 2'd3;
    chk_raise = 4'b1000;
    release_and_wait();
    expect_d("R3 check secure", 1'b1, 2'd3, 6'd51, 1'b0);
    step();
  endtask

  task automatic t_trap();
    cur_layer = 2'd0; trap_req = 1'b1;
    release_and_wait();
    expect_d("R8 R4 trap user", 1'b1, 2'd1, 6'd32, 1'b1);
    cur_layer = 2'd3; trap_req = 1'b1;
    release_and_wait();
    expect_d("R4 trap secure", 1'b1, 2'd3, 6'd32, 1'b1);
    step();
  endtask

  task automatic t_arith();
    cur_layer = 2'd1; ar_en = '0;
    ar_raise = 8'b0000_1000;
    release_and_wait();
    expect_d("R5 unrecognized", 1'b0, 2'd0, 6'd0, 1'b0);
    ar_en = 8'hff;
    step(); step();
    expect_d("R5 late enable", 1'b0, 2'd0, 6'd0, 1'b0);
    ar_disp = 16'h0000;
    ar_disp[7:6] = 2'd1;
    ar_raise = 8'b0000_1000;
    release_and_wait();
    expect_d("R6 repair", 1'b1, 2'd2, 6'd27, 1'b0);
    ar_disp[1:0] = 2'd2;
    ar_raise = 8'b0000_0001;
    release_and_wait();
    expect_d("R6 complete", 1'b1, 2'd2, 6'd24, 1'b1);
    ar_disp[15:14] = 2'd0;
    ar_raise = 8'b1000_0000;
    release_and_wait();
    expect_d("R6 terminate", 1'b1, 2'd2, 6'd31, 1'b1);
    step();
  endtask

  task automatic t_pf();
    cur_layer = 2'd0; pf_raise = 2'b01;
    release_and_wait();
    expect_d("R7 guest pf", 1'b1, 2'd1, 6'd16, 1'b0);
    cur_layer = 2'd1; pf_raise = 2'b10;
    release_and_wait();
    expect_d("R7 hyp pf", 1'b1, 2'd2, 6'd17, 1'b0);
    ar_en = 8'hff; ar_disp = '0;
    pf_raise = 2'b10; ar_raise = 8'b0000_0001;
    release_and_wait();
    expect_d("R2 pf before arith", 1'b1, 2'd2, 6'd17, 1'b0);
    step();
    expect_d("R2 arith after pf", 1'b1, 2'd2, 6'd24, 1'b1);
    step();
  endtask

  task automatic t_priority();
    cur_layer = 2'd0; ar_en = 8'hff; ar_disp = '0; ar_disp[3:2] = 2'd1;
    chk_raise = 4'b0101; ar_raise = 8'b0000_0010; trap_req = 1'b1; irq_raise = 8'b0000_0001;
    release_and_wait();
    expect_d("R2 check0 first", 1'b1, 2'd3, 6'd48, 1'b0);
    step();
    expect_d("R2 check2 next", 1'b1, 2'd3, 6'd50, 1'b0);
    step();
    expect_d("R2 exception", 1'b1, 2'd1, 6'd25, 1'b0);
    step();
    expect_d("R2 trap", 1'b1, 2'd1, 6'd32, 1'b1);
    step();
    expect_d("R2 R9 irq", 1'b1, 2'd1, 6'd0, 1'b0);
    step();
    expect_d("R2 drained", 1'b0, 2'd0, 6'd0, 1'b0);
  endtask

  task automatic t_irq();
    cur_layer = 2'd1; cur_hv = 4'd3; cur_gos = 4'd4;
    irq_raise = 8'b0000_0100;
    release_and_wait();
    expect_d("R9 mismatch held", 1'b0, 2'd0, 6'd0, 1'b0);
    step(); step();
    expect_d("R9 still held", 1'b0, 2'd0, 6'd0, 1'b0);
    cur_gos = 4'd5;
    step();
    expect_d("R9 taken on match", 1'b1, 2'd2, 6'd2, 1'b0);
    step();
    expect_d("R9 taken once", 1'b0, 2'd0, 6'd0, 1'b0);
    cur_hv = 4'd1; cur_gos = 4'd1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got cycle=%0d, expected end before 5000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_IRQ; i++) begin
      irq_hv[i*ID_W +: ID_W]  = 4'd1;
      irq_gos[i*ID_W +: ID_W] = 4'd1;
    end
    irq_hv[2*ID_W +: ID_W]  = 4'd3;
    irq_gos[2*ID_W +: ID_W] = 4'd5;
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_check();
    t_trap();
    t_arith();
    t_pf();
    t_priority();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule